// File: doc/BRIEF.md
# Four-Pin Interrupt Debounce Filter

This block cleans up four raw interrupt pin levels before they reach interrupt latching logic. Each pin first passes through a two-stage synchronizer. When a pin's filter is turned on and the pin is set up as level-sensitive, its filtered output follows the synchronized input only after that input has differed from the output for a selected number of timebase ticks in a row. Any return to the current output value before the count completes throws the count away.

All configuration lives in one 32-bit control word with one byte per pin. Software changes the word through a set address and a clear address, and reads it back whole on a separate read port. Each byte carries an enable, a self-clearing counter-restart request and a 4-bit time index. The index selects a tick count from a doubling series. An index past the last series entry uses the longest count. A pin whose filter is off, or whose pin is edge-sensitive, passes the synchronized level straight through. The prescaled timebase tick comes from outside the block.

Top module: `dbnc_filter4`

## Requirements
- R1: The control word holds byte n (bits 8n+7 to 8n) for pin n. Within a byte, bit 0 is the enable and bits 7:4 are the time index. The restart bit (bit 1) and bits 3:2 always read back as 0, and the whole word reads back on `cfg_rdata` from the cycle after a write.
- R2: A write with `cfg_addr` = 1 sets every storable control bit that is 1 in `cfg_wdata`. Writes with `cfg_addr` = 0 or 3 leave the word unchanged.
- R3: A write with `cfg_addr` = 2 clears every control bit that is 1 in `cfg_wdata` and leaves the other bits as they were.
- R4: Writing 1 to a pin's restart bit through the set address returns that pin's stability count to zero by the second clock edge after the write. Counting then starts again from zero.
- R5: For an enabled, level-sensitive pin with tick held high and a selected count L, a change on `pin_raw` applied before edge c+1 is absent from `pin_filt` after edge c+1+L and present after edge c+2+L.
- R6: A filtered pin whose synchronized input returns to the output value before the count completes does not change. A glitch held for fewer than L synchronized cycles never reaches `pin_filt`.
- R7: The stability count advances only on clock edges where `tick` is high. While `tick` is low, an enabled filtered output holds its value.
- R8: Time index i selects BASE_TICKS·2^i ticks for i below NUM_SEL. Any larger index selects BASE_TICKS·2^(NUM_SEL−1). The defaults give 4 ticks for index 1, 16 for index 3 and 128 for index 15.
- R9: A pin whose enable bit is 0, or whose `pin_level` is 0 (edge-sensitive), shows its raw input on `pin_filt` after exactly two clock edges.
- R10: After reset the control word reads 0 and all filtered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled timebase tick that advances the stability counts |
| pin_raw | input | 4 | Raw asynchronous pin levels |
| pin_level | input | 4 | Per-pin sensitivity: 1 level-sensitive, 0 edge-sensitive |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 2 | Write target: 1 set, 2 clear, others ignored |
| cfg_wdata | input | 32 | Write-one mask for the selected operation |
| cfg_rdata | output | 32 | Control word readback |
| pin_filt | output | 4 | Filtered pin levels |

## Verification
The hardest case to reach is a restart request that lands while a count is partway through. The only sign of it at the ports is that the output switches later than the undisturbed count would allow. The stimulus starts a level change on a 16-tick pin, issues the restart write five cycles later, and expects the output switch at the edge that follows a fresh full count from the restart edge. Checking at that edge rules out both an ignored restart and a count that resumed from its old value. The saturated index gets the same exact-edge treatment over 128 ticks, and a bounce three counts long shows that the count was thrown away.

// File: rtl/dbnc_filter4.sv
module dbnc_filter4 #(
  parameter int BASE_TICKS = 2,
  parameter int NUM_SEL    = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [3:0]  pin_raw,
  input  logic [3:0]  pin_level,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic [3:0]  pin_filt
);
  localparam int PINS      = 4;
  localparam int MAX_TICKS = BASE_TICKS << (NUM_SEL - 1);
  localparam int CW        = $clog2(MAX_TICKS + 1);
  localparam logic [1:0]  ADDR_SET = 2'd1;
  localparam logic [1:0]  ADDR_CLR = 2'd2;
  localparam logic [31:0] KEEP     = 32'hF1F1_F1F1;

  logic [31:0]        ctrl_q;
  logic [PINS-1:0]    restart_q, sync1_q, sync2_q, active;
  logic [PINS*CW-1:0] cnt_all;

  wire set_we = cfg_we && (cfg_addr == ADDR_SET);
  wire clr_we = cfg_we && (cfg_addr == ADDR_CLR);

  function automatic logic [CW-1:0] sel_limit(input logic [3:0] sel);
    int idx;
    idx = (int'(sel) >= NUM_SEL) ? NUM_SEL - 1 : int'(sel);
    return CW'(BASE_TICKS << idx);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      restart_q <= '0;
      sync1_q   <= '0;
      sync2_q   <= '0;
    end else begin
      if (set_we)      ctrl_q <= ctrl_q | (cfg_wdata & KEEP);
      else if (clr_we) ctrl_q <= ctrl_q & ~(cfg_wdata & KEEP);
      for (int n = 0; n < PINS; n++)
        restart_q[n] <= set_we && cfg_wdata[8*n+1];
      sync1_q <= pin_raw;
      sync2_q <= sync1_q;
    end
  end

  assign cfg_rdata = ctrl_q;

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    logic [CW-1:0] cnt;
    logic          filt;
    wire  [CW-1:0] limit = sel_limit(ctrl_q[8*n+7 -: 4]);

    assign active[n] = ctrl_q[8*n] && pin_level[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        filt <= 1'b0;
      end else if (!active[n]) begin
        cnt  <= '0;
        filt <= sync2_q[n];
      end else if (restart_q[n] || (sync2_q[n] == filt)) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt + 1'b1 >= limit) begin
          cnt  <= '0;
          filt <= sync2_q[n];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign cnt_all[n*CW +: CW] = cnt;
    assign pin_filt[n] = active[n] ? filt : sync2_q[n];
  end
endmodule

// File: rtl/dbnc_filter4_chk.sv
module dbnc_filter4_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [3:0]    pin_raw,
  input logic [3:0]    pin_level,
  input logic          cfg_we,
  input logic [1:0]    cfg_addr,
  input logic [31:0]   cfg_wdata,
  input logic [31:0]   cfg_rdata,
  input logic [3:0]    pin_filt,
  input logic [4*CW-1:0] cnt_all
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & 32'h0E0E_0E0E) == 32'h0);

  assert_set_merges_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd1) |=>
      ((cfg_rdata & $past(cfg_wdata) & 32'hF1F1_F1F1) == ($past(cfg_wdata) & 32'hF1F1_F1F1)));

  assert_clr_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd2) |=> ((cfg_rdata & $past(cfg_wdata)) == 32'h0));

  for (genvar n = 0; n < 4; n++) begin : g_chk
    wire act = cfg_rdata[8*n] && pin_level[n];

    assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 2'd1 && cfg_wdata[8*n+1]) |-> ##2 (cnt_all[n*CW +: CW] == '0));

    assert_change_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act && $past(act) && (pin_filt[n] != $past(pin_filt[n]))) |-> $past(tick));

    assert_bypass_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!act && $past(rst_n) && $past(rst_n, 2)) |-> (pin_filt[n] == $past(pin_raw[n], 2)));
  end
endmodule

bind dbnc_filter4 dbnc_filter4_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pin_raw(pin_raw), .pin_level(pin_level),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .pin_filt(pin_filt), .cnt_all(cnt_all)
);

// File: tb/dbnc_filter4_tb.sv
module dbnc_filter4_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic [3:0]  pin_raw = '0;
  logic [3:0]  pin_level = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  pin_filt;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    int    at;
    int    pin;
    bit    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbnc_filter4 u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_raw(pin_raw), .pin_level(pin_level),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pin_filt(pin_filt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_pin(input int dc, input int pin, input bit v, input string tag);
    exp_t e;
    e.at = cyc + dc; e.pin = pin; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        check(sb[i].tag, 32'(pin_filt[sb[i].pin]), 32'(sb[i].val));
        sb.delete(i);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = '0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ctrl after reset", cfg_rdata, 32'h0);
    check("R10 filt after reset", 32'(pin_filt), 32'h0);

    wr(2'd1, 32'h5A3C_96FF);
    check("R1 readback layout", cfg_rdata, 32'h5030_90F1);
    wr(2'd0, 32'hFFFF_FFFF);
    check("R2 addr 0 ignored", cfg_rdata, 32'h5030_90F1);
    wr(2'd3, 32'hFFFF_FFFF);
    check("R2 addr 3 ignored", cfg_rdata, 32'h5030_90F1);
    wr(2'd1, 32'h0000_0100);
    check("R2 set merges", cfg_rdata, 32'h5030_91F1);
    wr(2'd2, 32'h00F0_0001);
    check("R3 clear selected", cfg_rdata, 32'h5000_91F0);
    wr(2'd2, 32'hFFFF_FFFF);
    check("R3 clear all", cfg_rdata, 32'h0);

    pin_raw[0] = 1'b1;
    expect_pin(1, 0, 1'b0, "R9 disabled before");
    expect_pin(2, 0, 1'b1, "R9 disabled after");
    idle(4);
    wr(2'd1, 32'h0000_0101);
    pin_raw[1] = 1'b1;
    expect_pin(1, 1, 1'b0, "R9 edge pin before");
    expect_pin(2, 1, 1'b1, "R9 edge pin after");
    idle(4);
    wr(2'd2, 32'hFFFF_FFFF);
    pin_raw = '0;
    idle(5);

    pin_level = 4'hF;
    wr(2'd1, 32'h0000_0011);
    idle(2);
    pin_raw[0] = 1'b1;
    expect_pin(5, 0, 1'b0, "R5 L=4 before");
    expect_pin(6, 0, 1'b1, "R5 L=4 after");
    idle(10);

    wr(2'd1, 32'h0031_0000);
    idle(2);
    pin_raw[2] = 1'b1;
    expect_pin(17, 2, 1'b0, "R8 idx3 rise before");
    expect_pin(18, 2, 1'b1, "R8 idx3 rise after");
    idle(25);
    pin_raw[2] = 1'b0;
    expect_pin(17, 2, 1'b1, "R5 idx3 fall before");
    expect_pin(18, 2, 1'b0, "R5 idx3 fall after");
    idle(25);

    wr(2'd1, 32'hF100_0000);
    idle(2);
    pin_raw[3] = 1'b1;
    expect_pin(129, 3, 1'b0, "R8 saturated before");
    expect_pin(130, 3, 1'b1, "R8 saturated after");
    idle(135);

    pin_raw[0] = 1'b0;
    idle(3);
    pin_raw[0] = 1'b1;
    expect_pin(3, 0, 1'b1, "R6 bounce hold a");
    expect_pin(5, 0, 1'b1, "R6 bounce hold b");
    expect_pin(9, 0, 1'b1, "R6 bounce hold c");
    idle(12);

    tick = 1'b0;
    pin_raw[0] = 1'b0;
    expect_pin(10, 0, 1'b1, "R7 frozen mid");
    expect_pin(20, 0, 1'b1, "R7 frozen end");
    idle(20);
    tick = 1'b1;
    expect_pin(3, 0, 1'b1, "R7 resume before");
    expect_pin(4, 0, 1'b0, "R7 resume after");
    idle(8);

    pin_raw[2] = 1'b1;
    idle(5);
    wr(2'd1, 32'h0002_0000);
    check("R4 restart bit reads 0", cfg_rdata & 32'h00FF_0000, 32'h0031_0000);
    expect_pin(11, 2, 1'b0, "R4 restart delays switch");
    expect_pin(16, 2, 1'b0, "R4 restart before");
    expect_pin(17, 2, 1'b1, "R4 restart after");
    idle(25);

    done = 1;
  end

  initial begin
    for (int k = 0; k < 20000 && !done; k++) @(posedge clk);
    @(negedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule